// File: doc/BRIEF.md
# Microcoded 16-bit Execute Datapath

This block is the execute stage of a microcoded processor core. Every clock it takes one 32-bit microinstruction word and decodes four fields from it: an ALU function, a destination code and two operand source codes. Two 16-bit operand selectors read from the architectural state. That state holds four scratch words, the 8-bit accumulator and the two 8-bit index registers, the program counter, the stack pointer, the flags byte, the memory address register, the write-data byte, a status word and a 5-bit control word. The selectors can also read the memory read byte, zero or a 16-bit immediate.

A five-function ALU combines the two operands. Its result is written back into the selected destination at the next rising edge. Adds also record a carry out of bit 7 and a signed-overflow bit. Those two bits, a latched NMI edge and a masked interrupt request together make up the status word that the microcode can test.

The block drives the memory address, the write byte and the control lines, whose bit 0 is the read/write-not line. It also returns the last written-back result, which an outside sequencer uses for its zero tests. Sequencing, the microcode store and memory are outside this block.

Top module: `uexec_datapath`

## Requirements
- R1: After reset every register reads zero except the program counter, which reads 0x0400, and the NMI history, which holds "high". All outputs are zero after reset.
- R2: The ALU function is `uinst[31:28]`. 2 adds, 3 ANDs, 4 ORs and 5 XORs the two operands. 6 shifts operand 0 right by one with a zero fill. Any other value produces 0xEEEE.
- R3: A write-back to the destination `uinst[27:24]` and to `last_result` happens only when `uinst[31:28]` is 2 or more. Otherwise all architectural state is unchanged.
- R4: Operand 0 is `uinst[23:20]` and operand 1 is `uinst[19:16]`. The source and destination codes are: 0–3 scratch, 4 accumulator, 5 X index, 6 Y index, 7 program counter, 8 stack pointer, 9 flags, A address, B data byte, C status and D control. Codes C, E and F as a destination write nothing.
- R5: Reading the stack pointer returns 0x0100 ORed with its 8-bit value.
- R6: Operand 1 code 7 returns the program counter with its two bytes swapped, while operand 0 code 7 returns it unchanged. Code B returns `rd_data` in both bytes. Operand 1 code F returns `uinst[15:0]`. Operand 0 codes E and F and operand 1 code E return zero.
- R7: An add sets carry8 to the carry out of bit 7 of the low bytes and overflow to carry8 XOR the carry into bit 7. Other functions leave both unchanged. The status word is: bit 0 carry8, bit 3 NMI latch, bit 5 gated IRQ, bit 6 overflow, all other bits zero.
- R8: The accumulator, index, stack pointer and data destinations keep the low result byte. A flags write stores the low byte ORed with 0x30. The control word keeps the low 5 result bits.
- R9: The NMI latch sets when `nmi_n` was 1 at the previous edge and is 0 at this edge. `nmi_clear` clears it and wins over a new edge.
- R10: At each edge the gated IRQ bit takes `irq_req` AND NOT flags bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| uinst | input | 32 | Current microinstruction word |
| rd_data | input | 8 | Memory read byte |
| nmi_n | input | 1 | Active-low non-maskable interrupt line |
| nmi_clear | input | 1 | Clears the NMI latch |
| irq_req | input | 1 | Interrupt request, masked by flags bit 2 |
| addr_out | output | 16 | Memory address register |
| wr_data | output | 8 | Memory write byte |
| ctl_out | output | 5 | Control word, bit 0 read/write-not |
| last_result | output | 16 | Most recent written-back ALU result |

## Verification
Long runs of random microinstruction words mix every function code, including the codes that produce 0xEEEE and the non-writing codes 0 and 1, with every source and destination pairing. The bench watches the address, data, control and last-result ports through a reference model, so wrong mux codes, wrong byte masking or wrong write enables show up as mismatches.

Directed sequences then move single registers to the address port. This separates the byte-swapped program counter, the page-one stack pointer, the duplicated data byte and the forced flags bits from their plain readings. A 0x80+0x80 add separates carry8 from overflow. Stepped NMI, clear and IRQ patterns, with the mask bit both clear and set, isolate each status bit.

// File: rtl/uexec_pkg.sv
package uexec_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int SCR_N  = 4;
    localparam int CTL_W  = 5;
    localparam int SEL_W  = 4;
    localparam int UI_W   = 32;
    localparam int SCR_IW = $clog2(SCR_N);

    localparam logic [WORD_W-1:0] PC_RESET  = 16'h0400;
    localparam logic [WORD_W-1:0] BAD_RES   = 16'hEEEE;
    localparam logic [WORD_W-1:0] SP_PAGE   = 16'h0100;
    localparam logic [BYTE_W-1:0] FLG_FORCE = 8'h30;

    // ALU function codes
    localparam logic [SEL_W-1:0] FN_ADD = 4'h2;
    localparam logic [SEL_W-1:0] FN_AND = 4'h3;
    localparam logic [SEL_W-1:0] FN_OR  = 4'h4;
    localparam logic [SEL_W-1:0] FN_XOR = 4'h5;
    localparam logic [SEL_W-1:0] FN_SHR = 4'h6;

    typedef enum logic [SEL_W-1:0] {
        LOC_S0  = 4'h0, LOC_S1  = 4'h1, LOC_S2  = 4'h2, LOC_S3  = 4'h3,
        LOC_ACC = 4'h4, LOC_IX  = 4'h5, LOC_IY  = 4'h6, LOC_PC  = 4'h7,
        LOC_SP  = 4'h8, LOC_FLG = 4'h9, LOC_ADR = 4'hA, LOC_DAT = 4'hB,
        LOC_STS = 4'hC, LOC_CTL = 4'hD, LOC_ZRO = 4'hE, LOC_IMM = 4'hF
    } loc_e;

    typedef struct packed {
        logic [SCR_N-1:0][WORD_W-1:0] scr;
        logic [BYTE_W-1:0]            acc;
        logic [BYTE_W-1:0]            ix;
        logic [BYTE_W-1:0]            iy;
        logic [WORD_W-1:0]            pc;
        logic [BYTE_W-1:0]            sp;
        logic [BYTE_W-1:0]            flg;
        logic [WORD_W-1:0]            adr;
        logic [BYTE_W-1:0]            wdat;
        logic [CTL_W-1:0]             ctl;
    } arch_t;

    typedef struct packed {
        arch_t             arch;
        logic [WORD_W-1:0] last;
        logic              c8;
        logic              ovf;
        logic              nmi_lat;
        logic              nmi_hist;
        logic              irq_g;
    } state_t;

endpackage

// File: rtl/uexec_alu.sv
module uexec_alu
    import uexec_pkg::*;
(
    input  logic [SEL_W-1:0]  fn,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic [WORD_W-1:0] res,
    output logic              is_add,
    output logic              c8,
    output logic              ovf
);

    localparam int LOW_W = BYTE_W - 1;

    logic [BYTE_W:0]   low_sum;
    logic [LOW_W:0]    sub_sum;
    logic              c7;

    always_comb begin
        low_sum = {1'b0, opa[BYTE_W-1:0]} + {1'b0, opb[BYTE_W-1:0]};
        sub_sum = {1'b0, opa[LOW_W-1:0]} + {1'b0, opb[LOW_W-1:0]};
        c7      = sub_sum[LOW_W];
        c8      = low_sum[BYTE_W];
        ovf     = c7 ^ c8;
        is_add  = (fn == FN_ADD);
        unique case (fn)
            FN_ADD:  res = opa + opb;
            FN_AND:  res = opa & opb;
            FN_OR:   res = opa | opb;
            FN_XOR:  res = opa ^ opb;
            FN_SHR:  res = {1'b0, opa[WORD_W-1:1]};
            default: res = BAD_RES;
        endcase
    end

endmodule

// File: rtl/uexec_opsel.sv
module uexec_opsel
    import uexec_pkg::*;
#(
    parameter bit SWAP_PC = 1'b0
) (
    input  arch_t             st,
    input  logic [BYTE_W-1:0] rdat,
    input  logic [WORD_W-1:0] status,
    input  logic [WORD_W-1:0] top_val,
    input  logic [SEL_W-1:0]  sel,
    output logic [WORD_W-1:0] val
);

    logic [WORD_W-1:0] pc_view;

    generate
        if (SWAP_PC) begin : g_swap
            assign pc_view = {st.pc[BYTE_W-1:0], st.pc[WORD_W-1:BYTE_W]};
        end else begin : g_plain
            assign pc_view = st.pc;
        end
    endgenerate

    always_comb begin
        unique case (loc_e'(sel))
            LOC_S0, LOC_S1, LOC_S2, LOC_S3:
                     val = st.scr[sel[SCR_IW-1:0]];
            LOC_ACC: val = {{(WORD_W-BYTE_W){1'b0}}, st.acc};
            LOC_IX:  val = {{(WORD_W-BYTE_W){1'b0}}, st.ix};
            LOC_IY:  val = {{(WORD_W-BYTE_W){1'b0}}, st.iy};
            LOC_PC:  val = pc_view;
            LOC_SP:  val = SP_PAGE | {{(WORD_W-BYTE_W){1'b0}}, st.sp};
            LOC_FLG: val = {{(WORD_W-BYTE_W){1'b0}}, st.flg};
            LOC_ADR: val = st.adr;
            LOC_DAT: val = {rdat, rdat};
            LOC_STS: val = status;
            LOC_CTL: val = {{(WORD_W-CTL_W){1'b0}}, st.ctl};
            LOC_ZRO: val = '0;
            default: val = top_val;
        endcase
    end

endmodule

// File: rtl/uexec_state.sv
module uexec_state
    import uexec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_en,
    input  logic [SEL_W-1:0]  dst,
    input  logic [WORD_W-1:0] alu_res,
    input  logic              is_add,
    input  logic              add_c8,
    input  logic              add_ovf,
    input  logic              nmi_n,
    input  logic              nmi_clear,
    input  logic              irq_req,
    output arch_t             arch_q,
    output logic [WORD_W-1:0] status_q,
    output logic [WORD_W-1:0] last_q
);

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (is_add) begin
            st_d.c8  = add_c8;
            st_d.ovf = add_ovf;
        end
        if (wb_en) begin
            st_d.last = alu_res;
            unique case (loc_e'(dst))
                LOC_S0, LOC_S1, LOC_S2, LOC_S3:
                         st_d.arch.scr[dst[SCR_IW-1:0]] = alu_res;
                LOC_ACC: st_d.arch.acc  = alu_res[BYTE_W-1:0];
                LOC_IX:  st_d.arch.ix   = alu_res[BYTE_W-1:0];
                LOC_IY:  st_d.arch.iy   = alu_res[BYTE_W-1:0];
                LOC_PC:  st_d.arch.pc   = alu_res;
                LOC_SP:  st_d.arch.sp   = alu_res[BYTE_W-1:0];
                LOC_FLG: st_d.arch.flg  = alu_res[BYTE_W-1:0] | FLG_FORCE;
                LOC_ADR: st_d.arch.adr  = alu_res;
                LOC_DAT: st_d.arch.wdat = alu_res[BYTE_W-1:0];
                LOC_CTL: st_d.arch.ctl  = alu_res[CTL_W-1:0];
                default: ;
            endcase
        end
        st_d.nmi_hist = nmi_n;
        if (nmi_clear)
            st_d.nmi_lat = 1'b0;
        else if (st_q.nmi_hist && !nmi_n)
            st_d.nmi_lat = 1'b1;
        st_d.irq_g = irq_req & ~st_q.arch.flg[2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.arch.pc  <= PC_RESET;
            st_q.nmi_hist <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign arch_q   = st_q.arch;
    assign last_q   = st_q.last;
    assign status_q = {{(WORD_W-7){1'b0}}, st_q.ovf, st_q.irq_g, 1'b0,
                       st_q.nmi_lat, 2'b00, st_q.c8};

    // R3
    hold_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_en |=> $stable(st_q.last));

    // R7
    hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_add |=> ($stable(st_q.c8) && $stable(st_q.ovf)));

    // R8
    flag_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && dst == LOC_FLG) |=> (st_q.arch.flg[5:4] == 2'b11));

    // R9
    nmi_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_clear |=> !st_q.nmi_lat);

    // R9
    nmi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi_clear && $fell(nmi_n)) |=> st_q.nmi_lat);

    // R1
    pc_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st_q.arch.pc == PC_RESET));

endmodule

// File: rtl/uexec_datapath.sv
module uexec_datapath
    import uexec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [UI_W-1:0]   uinst,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              nmi_n,
    input  logic              nmi_clear,
    input  logic              irq_req,
    output logic [WORD_W-1:0] addr_out,
    output logic [BYTE_W-1:0] wr_data,
    output logic [CTL_W-1:0]  ctl_out,
    output logic [WORD_W-1:0] last_result
);

    logic [SEL_W-1:0]  fn, dst, sel_a, sel_b;
    logic [WORD_W-1:0] imm;
    logic [WORD_W-1:0] opa, opb, alu_res, status;
    logic              wb_en, is_add, add_c8, add_ovf;
    arch_t             arch;

    assign fn    = uinst[31:28];
    assign dst   = uinst[27:24];
    assign sel_a = uinst[23:20];
    assign sel_b = uinst[19:16];
    assign imm   = uinst[15:0];
    assign wb_en = (fn >= FN_ADD);

    uexec_opsel #(.SWAP_PC(1'b0)) u_sel_a (
        .st(arch), .rdat(rd_data), .status(status), .top_val('0),
        .sel(sel_a), .val(opa)
    );

    uexec_opsel #(.SWAP_PC(1'b1)) u_sel_b (
        .st(arch), .rdat(rd_data), .status(status), .top_val(imm),
        .sel(sel_b), .val(opb)
    );

    uexec_alu u_alu (
        .fn(fn), .opa(opa), .opb(opb), .res(alu_res),
        .is_add(is_add), .c8(add_c8), .ovf(add_ovf)
    );

    uexec_state u_state (
        .clk(clk), .rst_n(rst_n), .wb_en(wb_en), .dst(dst),
        .alu_res(alu_res), .is_add(is_add), .add_c8(add_c8),
        .add_ovf(add_ovf), .nmi_n(nmi_n), .nmi_clear(nmi_clear),
        .irq_req(irq_req), .arch_q(arch), .status_q(status),
        .last_q(last_result)
    );

    assign addr_out = arch.adr;
    assign wr_data  = arch.wdat;
    assign ctl_out  = arch.ctl;

    // R2
    and_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == FN_AND) |-> ((alu_res & ~opa) == '0));

    // R2
    shr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == FN_SHR) |-> (alu_res[WORD_W-1] == 1'b0));

    // R5
    sp_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a == LOC_SP) |-> (opa[WORD_W-1:BYTE_W] == 8'h01));

endmodule

// File: tb/uexec_datapath_tb.sv
module uexec_datapath_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] uinst = '0;
    logic [7:0]  rd_data = '0;
    logic        nmi_n = 1'b1, nmi_clear = 1'b0, irq_req = 1'b0;
    logic [15:0] addr_out, last_result;
    logic [7:0]  wr_data;
    logic [4:0]  ctl_out;

    int errors = 0;
    int checks = 0;

    // reference state
    logic [15:0] m_scr [4];
    logic [7:0]  m_acc, m_ix, m_iy, m_sp, m_flg, m_wd;
    logic [15:0] m_pc, m_adr, m_last;
    logic [4:0]  m_ctl;
    logic        m_c8, m_ov, m_nmi, m_hist, m_irq;

    always #4 clk = ~clk;

    uexec_datapath u_dut (
        .clk(clk), .rst_n(rst_n), .uinst(uinst), .rd_data(rd_data),
        .nmi_n(nmi_n), .nmi_clear(nmi_clear), .irq_req(irq_req),
        .addr_out(addr_out), .wr_data(wr_data), .ctl_out(ctl_out),
        .last_result(last_result)
    );

    function automatic logic [31:0] mk(input logic [3:0] f, input logic [3:0] d,
                                       input logic [3:0] a, input logic [3:0] b,
                                       input logic [15:0] im);
        return {f, d, a, b, im};
    endfunction

    function automatic logic [15:0] m_status();
        return {9'b0, m_ov, m_irq, 1'b0, m_nmi, 2'b00, m_c8};
    endfunction

    function automatic logic [15:0] m_read(input logic [3:0] s, input bit second,
                                           input logic [15:0] im, input logic [7:0] rd);
        case (s)
            4'h0, 4'h1, 4'h2, 4'h3: return m_scr[s[1:0]];
            4'h4: return {8'h00, m_acc};
            4'h5: return {8'h00, m_ix};
            4'h6: return {8'h00, m_iy};
            4'h7: return second ? {m_pc[7:0], m_pc[15:8]} : m_pc;
            4'h8: return {8'h01, m_sp};
            4'h9: return {8'h00, m_flg};
            4'hA: return m_adr;
            4'hB: return {rd, rd};
            4'hC: return m_status();
            4'hD: return {11'b0, m_ctl};
            4'hE: return 16'h0000;
            default: return second ? im : 16'h0000;
        endcase
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 4; i++) m_scr[i] = '0;
        m_acc = '0; m_ix = '0; m_iy = '0; m_sp = '0; m_flg = '0; m_wd = '0;
        m_pc = 16'h0400; m_adr = '0; m_last = '0; m_ctl = '0;
        m_c8 = 0; m_ov = 0; m_nmi = 0; m_hist = 1; m_irq = 0;
    endtask

    task automatic m_step();
        logic [15:0] a, b, r;
        logic [3:0]  f, d;
        logic        c7, c8;
        f = uinst[31:28]; d = uinst[27:24];
        a = m_read(uinst[23:20], 0, uinst[15:0], rd_data);
        b = m_read(uinst[19:16], 1, uinst[15:0], rd_data);
        case (f)
            4'h2: r = a + b;
            4'h3: r = a & b;
            4'h4: r = a | b;
            4'h5: r = a ^ b;
            4'h6: r = a >> 1;
            default: r = 16'hEEEE;
        endcase
        // NMI and IRQ use pre-edge state
        if (nmi_clear) m_nmi = 0;
        else if (m_hist && !nmi_n) m_nmi = 1;
        m_hist = nmi_n;
        m_irq = irq_req & ~m_flg[2];
        if (f == 4'h2) begin
            c7 = 8'((a[6:0] + b[6:0])) >> 7;
            c8 = 9'((a[7:0] + b[7:0])) >> 8;
            m_c8 = c8; m_ov = c7 ^ c8;
        end
        if (f >= 4'h2) begin
            m_last = r;
            case (d)
                4'h0, 4'h1, 4'h2, 4'h3: m_scr[d[1:0]] = r;
                4'h4: m_acc = r[7:0];
                4'h5: m_ix = r[7:0];
                4'h6: m_iy = r[7:0];
                4'h7: m_pc = r;
                4'h8: m_sp = r[7:0];
                4'h9: m_flg = r[7:0] | 8'h30;
                4'hA: m_adr = r;
                4'hB: m_wd = r[7:0];
                4'hD: m_ctl = r[4:0];
                default: ;
            endcase
        end
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic [31:0] ui, input logic [7:0] rd,
                        input logic nn, input logic nc, input logic iq);
        @(negedge clk);
        uinst = ui; rd_data = rd; nmi_n = nn; nmi_clear = nc; irq_req = iq;
        m_step();
        @(posedge clk);
        #1;
        check({tag, " addr_out"}, addr_out, m_adr);
        check({tag, " wr_data"}, {8'h00, wr_data}, {8'h00, m_wd});
        check({tag, " ctl_out"}, {11'b0, ctl_out}, {11'b0, m_ctl});
        check({tag, " last_result"}, last_result, m_last);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R1 addr", addr_out, 16'h0000);
        check("R1 last", last_result, 16'h0000);
        check("R1 ctl", {11'b0, ctl_out}, 16'h0000);
        @(negedge clk) rst_n = 1'b1;

        // R1: program counter visible through the address register
        step("R1", mk(4'h4, 4'hA, 4'h7, 4'hE, 16'h0), 8'h00, 1, 0, 0);
        check("R1 pc", addr_out, 16'h0400);
        // R6: byte swap on operand 1
        step("R6", mk(4'h4, 4'hA, 4'hE, 4'h7, 16'h0), 8'h00, 1, 0, 0);
        check("R6 pc swap", addr_out, 16'h0004);
        // R5: stack page one
        step("R5", mk(4'h4, 4'hA, 4'h8, 4'hE, 16'h0), 8'h00, 1, 0, 0);
        check("R5 sp", addr_out, 16'h0100);
        // R6: duplicated data byte
        step("R6", mk(4'h4, 4'hA, 4'hB, 4'hE, 16'h0), 8'h5A, 1, 0, 0);
        check("R6 data dup", addr_out, 16'h5A5A);
        // R8: flags force bits
        step("R8", mk(4'h4, 4'h9, 4'hE, 4'hF, 16'h0000), 8'h00, 1, 0, 0);
        step("R8", mk(4'h4, 4'hA, 4'h9, 4'hE, 16'h0), 8'h00, 1, 0, 0);
        check("R8 flags", addr_out, 16'h0030);
        // R8: control keeps low 5 bits
        step("R8", mk(4'h4, 4'hD, 4'hE, 4'hF, 16'hFFFF), 8'h00, 1, 0, 0);
        check("R8 ctl", {11'b0, ctl_out}, 16'h001F);
        // R2: undefined function
        step("R2", mk(4'h9, 4'hA, 4'h0, 4'h0, 16'h0), 8'h00, 1, 0, 0);
        check("R2 bad fn", addr_out, 16'hEEEE);
        // R3: non-writing function leaves last result
        step("R3", mk(4'h1, 4'hA, 4'hE, 4'hF, 16'h1234), 8'h00, 1, 0, 0);
        check("R3 hold", last_result, 16'hEEEE);
        // R7: carry and overflow
        step("R7", mk(4'h2, 4'h0, 4'hE, 4'hF, 16'h0080), 8'h00, 1, 0, 0);
        step("R7", mk(4'h2, 4'h1, 4'h0, 4'h0, 16'h0), 8'h00, 1, 0, 0);
        step("R7", mk(4'h4, 4'hA, 4'hC, 4'hE, 16'h0), 8'h00, 1, 0, 0);
        check("R7 status", addr_out, 16'h0041);
        // R9: NMI edge then clear
        step("R9", 32'h0, 8'h00, 1, 0, 0);
        step("R9", 32'h0, 8'h00, 0, 0, 0);
        step("R9", mk(4'h4, 4'hA, 4'hC, 4'hE, 16'h0), 8'h00, 0, 0, 0);
        check("R9 set", addr_out, 16'h0049);
        step("R9", 32'h0, 8'h00, 0, 1, 0);
        step("R9", mk(4'h4, 4'hA, 4'hC, 4'hE, 16'h0), 8'h00, 0, 0, 0);
        check("R9 clear", addr_out, 16'h0041);
        // R10: IRQ mask
        step("R10", 32'h0, 8'h00, 1, 0, 1);
        step("R10", mk(4'h4, 4'hA, 4'hC, 4'hE, 16'h0), 8'h00, 1, 0, 1);
        check("R10 unmasked", addr_out, 16'h0061);
        step("R10", mk(4'h4, 4'h9, 4'hE, 4'hF, 16'h0004), 8'h00, 1, 0, 1);
        step("R10", 32'h0, 8'h00, 1, 0, 1);
        step("R10", mk(4'h4, 4'hA, 4'hC, 4'hE, 16'h0), 8'h00, 1, 0, 1);
        check("R10 masked", addr_out, 16'h0041);

        // R2 R3 R4 R7 R8: random microinstructions
        void'($urandom(32'd4242));
        for (int n = 0; n < 3000; n++) begin
            step("R4 random", $urandom, 8'($urandom), 1'($urandom),
                 ($urandom % 8) == 0, 1'($urandom));
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule